// File: doc/BRIEF.md
# Buffer Descriptor Chain Walker

This block drives one transfer channel from a chain of buffer descriptors kept in a private descriptor store of 32-bit words. Each descriptor is four words long. The host fills the store through a plain word read/write port. It then writes the byte address of the first descriptor to start the engine. The engine reads each descriptor in turn. For every descriptor it hands a fragment request (buffer address, offset into the buffer and byte count) to an external data mover, and it holds that request until the mover acknowledges that the fragment is done.

Descriptors are grouped into packets by start and end marks. Only the first descriptor of a packet carries a valid hand-over (ownership) bit. The engine checks that bit before it moves any data for the packet. It clears the bit after the last fragment of the packet is acknowledged, so software can tell which packets it may reuse. When the packet that just finished is also the tail of the chain, the engine marks its last descriptor with an end-of-queue bit. Software that linked a new descriptor onto the tail too late can then see that the engine stopped, and restart it.

After every packet the engine pulses a done strobe. With that strobe it presents the address of the packet's last descriptor and the packet length taken from the packet's first descriptor. If the engine finds a malformed chain, it stops and reports an error code. If the host writes a start address while the engine is busy, the write has no effect and a protocol-error strobe is raised.

Top module: `bd_chain_walker`

## Requirements
- R1: After reset, and from the second clock edge after rst_n rises, busy, frag_req, pkt_done and proto_err are 0, err_code is 0 and cpl_ptr is 0.
- R2: A descriptor at byte address P occupies store words P/4 to P/4+3. Word 0 is the next-descriptor byte address. Word 1 is the buffer address. Word 2 holds the offset in bits 31:16 and the byte count in bits 15:0. Word 3 holds flags in bits 31:16 and the packet length in bits 15:0. The flag bits are start-of-packet 31, end-of-packet 30, ownership 29 and end-of-queue 28.
- R3: A start write (head_wr) of a nonzero address while idle makes busy 1 in the next cycle, and the walk begins at that descriptor. A start write of zero while idle leaves the engine idle.
- R4: For each descriptor processed, frag_req rises and stays high with frag_addr = word 1, frag_off = word 2 bits 31:16 and frag_len = word 2 bits 15:0, all stable until frag_ack is sampled high. Descriptors are served in chain order.
- R5: If the first descriptor of a packet has the ownership bit clear, no request is issued for it, the engine goes idle and err_code becomes 1. The ownership bit of the packet's later descriptors is ignored.
- R6: If the descriptor expected to start a packet lacks the start-of-packet bit, the engine goes idle with err_code 2. This check takes priority over the ownership check.
- R7: Once the end-of-packet fragment is acknowledged, the engine clears the ownership bit in the first descriptor's word 3 and keeps every other bit. Before then, the bit stays set.
- R8: If the end-of-packet descriptor's next pointer is zero, the engine sets bit 28 in that descriptor's word 3. Otherwise it sets no end-of-queue bit.
- R9: After each completed packet, pkt_done is high for exactly one cycle. In that cycle cpl_ptr equals the end-of-packet descriptor's address and done_len equals the packet length from the start-of-packet descriptor. The strobe comes 2 cycles after the acknowledge edge, or 3 cycles when a separate end-of-queue write is needed.
- R10: After a packet whose last descriptor has a nonzero next pointer, the walk continues at that address. If the next pointer is zero, busy is 0 in the pkt_done cycle.
- R11: An acknowledged fragment that is not end-of-packet and has a zero next pointer stops the engine with err_code 3 in the next cycle. No ownership bit is cleared.
- R12: A start write while busy has no effect on the walk, and proto_err is high for exactly the next cycle.
- R13: A host write stores a word. host_rdata returns the addressed word one cycle after host_addr is presented.
- R14: err_code keeps its value while the engine is idle, and it returns to 0 in the cycle after a start write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| head_wr | input | 1 | Start-address write strobe |
| head_wdata | input | 32 | Byte address of the first descriptor |
| host_we | input | 1 | Descriptor store write enable |
| host_addr | input | IDX_W (6) | Descriptor store word index |
| host_wdata | input | 32 | Descriptor store write data |
| host_rdata | output | 32 | Descriptor store read data, one cycle latency |
| frag_req | output | 1 | Fragment request to the data mover |
| frag_ack | input | 1 | Fragment completed by the data mover |
| frag_addr | output | 32 | Buffer address of the fragment |
| frag_off | output | 16 | Offset inside the buffer |
| frag_len | output | 16 | Fragment byte count |
| pkt_done | output | 1 | One-cycle strobe per finished packet |
| cpl_ptr | output | 32 | Address of the last descriptor of the finished packet |
| done_len | output | 16 | Packet length of the finished packet |
| busy | output | 1 | Engine is walking a chain |
| err_code | output | 2 | 0 none, 1 not owned, 2 missing start mark, 3 chain ends inside a packet |
| proto_err | output | 1 | One-cycle strobe for a start write while busy |

## Verification
After a start write, busy is due one cycle later. The first fragment request is due five cycles after the write edge, because each descriptor takes four fetch cycles and one check cycle. The done strobe follows the acknowledge edge by two cycles, or by three cycles when the end-of-queue word is written separately. A truncation error shows one cycle after the acknowledge edge, and a protocol-error strobe shows one cycle after the stray write. The bench drives and samples only on falling edges. It samples each of these results at its exact due cycle, and it counts the cycles up to the done strobe against the value it predicts. A result whose latency depends on chain contents, such as the arrival of the next request, is awaited with a bounded poll.

// File: rtl/bdw_pkg.sv
package bdw_pkg;
  localparam int WORD_W   = 32;
  localparam int HALF_W   = 16;
  localparam int BD_WORDS = 4;

  // flag positions inside descriptor word 3
  localparam int FLAG_SOP = 31;
  localparam int FLAG_EOP = 30;
  localparam int FLAG_OWN = 29;
  localparam int FLAG_EOQ = 28;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_CHECK  = 3'd2,
    ST_REQ    = 3'd3,
    ST_WB_EOQ = 3'd4,
    ST_WB_OWN = 3'd5
  } walk_state_e;

  typedef enum logic [1:0] {
    WERR_NONE      = 2'd0,
    WERR_NOT_OWNED = 2'd1,
    WERR_NO_SOP    = 2'd2,
    WERR_TRUNC     = 2'd3
  } walk_err_e;
endpackage

// File: rtl/bdw_desc_ram.sv
module bdw_desc_ram #(
  parameter int WORDS = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [AW-1:0] eng_raddr,
  output logic [DW-1:0] eng_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_waddr,
  input  logic [DW-1:0] eng_wdata
);
  logic [DW-1:0] mem [WORDS];
  logic          host_wr_en;

  // the engine's write wins when both ports hit the same word
  assign host_wr_en = host_we && !(eng_we && (eng_waddr == host_addr));

  always_ff @(posedge clk) begin
    if (eng_we)     mem[eng_waddr] <= eng_wdata;
    if (host_wr_en) mem[host_addr] <= host_wdata;
  end

  always_ff @(posedge clk) begin
    host_rdata <= mem[host_addr];
  end

  assign eng_rdata = mem[eng_raddr];
endmodule

// File: rtl/bdw_walk_ctrl.sv
module bdw_walk_ctrl
  import bdw_pkg::*;
#(
  parameter int RAM_WORDS = 64,
  localparam int IDX_W    = $clog2(RAM_WORDS),
  localparam int WIDX_W   = $clog2(BD_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_wr,
  input  logic [WORD_W-1:0] head_wdata,
  input  logic              frag_ack,
  output logic              frag_req,
  output logic [WORD_W-1:0] frag_addr,
  output logic [HALF_W-1:0] frag_off,
  output logic [HALF_W-1:0] frag_len,
  output logic              pkt_done,
  output logic [WORD_W-1:0] cpl_ptr,
  output logic [HALF_W-1:0] done_len,
  output logic              busy,
  output logic [1:0]        err_code,
  output logic              proto_err,
  output logic [IDX_W-1:0]  eng_raddr,
  input  logic [WORD_W-1:0] eng_rdata,
  output logic              eng_we,
  output logic [IDX_W-1:0]  eng_waddr,
  output logic [WORD_W-1:0] eng_wdata
);
  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(BD_WORDS - 1);

  function automatic logic [IDX_W-1:0] word_idx(input logic [WORD_W-1:0] p,
                                                input logic [WIDX_W-1:0] k);
    return p[IDX_W+1:2] + IDX_W'(k);
  endfunction

  walk_state_e       state_q, state_d;
  walk_err_e         err_q, err_d;
  logic [WORD_W-1:0] cur_q, cur_d;
  logic [WIDX_W-1:0] widx_q, widx_d;
  logic              in_pkt_q, in_pkt_d;
  logic              done_q, done_d;
  logic              proto_q, proto_d;
  logic [WORD_W-1:0] cpl_q, cpl_d;
  logic [HALF_W-1:0] dlen_q, dlen_d;
  logic [WORD_W-1:0] bd_q [BD_WORDS];
  logic [WORD_W-1:0] sop_ptr_q, sop_w3_q;
  logic [HALF_W-1:0] plen_q;
  logic              bd_en, sop_en;

  logic chain_end, is_eop, same_bd;
  assign chain_end = (bd_q[0] == '0);
  assign is_eop    = bd_q[3][FLAG_EOP];
  assign same_bd   = (cur_q == sop_ptr_q);

  // next-state logic
  always_comb begin
    state_d  = state_q;
    err_d    = err_q;
    cur_d    = cur_q;
    widx_d   = widx_q;
    in_pkt_d = in_pkt_q;
    cpl_d    = cpl_q;
    dlen_d   = dlen_q;
    done_d   = 1'b0;
    proto_d  = head_wr && (state_q != ST_IDLE);
    bd_en    = 1'b0;
    sop_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (head_wr && (head_wdata != '0)) begin
          cur_d    = head_wdata;
          widx_d   = '0;
          err_d    = WERR_NONE;
          in_pkt_d = 1'b0;
          state_d  = ST_FETCH;
        end
      end
      ST_FETCH: begin
        bd_en  = 1'b1;
        widx_d = widx_q + 1'b1;
        if (widx_q == LAST_W) state_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (in_pkt_q) begin
          state_d = ST_REQ;
        end else if (!bd_q[3][FLAG_SOP]) begin
          err_d   = WERR_NO_SOP;
          state_d = ST_IDLE;
        end else if (!bd_q[3][FLAG_OWN]) begin
          err_d   = WERR_NOT_OWNED;
          state_d = ST_IDLE;
        end else begin
          sop_en   = 1'b1;
          in_pkt_d = 1'b1;
          state_d  = ST_REQ;
        end
      end
      ST_REQ: begin
        if (frag_ack) begin
          if (is_eop) begin
            state_d = (chain_end && !same_bd) ? ST_WB_EOQ : ST_WB_OWN;
          end else if (chain_end) begin
            err_d   = WERR_TRUNC;
            state_d = ST_IDLE;
          end else begin
            cur_d   = bd_q[0];
            widx_d  = '0;
            state_d = ST_FETCH;
          end
        end
      end
      ST_WB_EOQ: begin
        state_d = ST_WB_OWN;
      end
      ST_WB_OWN: begin
        done_d   = 1'b1;
        cpl_d    = cur_q;
        dlen_d   = plen_q;
        in_pkt_d = 1'b0;
        if (chain_end) begin
          state_d = ST_IDLE;
        end else begin
          cur_d   = bd_q[0];
          widx_d  = '0;
          state_d = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // descriptor store access
  always_comb begin
    eng_raddr = word_idx(cur_q, widx_q);
    eng_we    = 1'b0;
    eng_waddr = word_idx(cur_q, LAST_W);
    eng_wdata = bd_q[3];
    if (state_q == ST_WB_EOQ) begin
      eng_we    = 1'b1;
      eng_wdata = bd_q[3] | (WORD_W'(1) << FLAG_EOQ);
    end else if (state_q == ST_WB_OWN) begin
      eng_we    = 1'b1;
      eng_waddr = word_idx(sop_ptr_q, LAST_W);
      eng_wdata = sop_w3_q & ~(WORD_W'(1) << FLAG_OWN);
      if (same_bd && chain_end) eng_wdata[FLAG_EOQ] = 1'b1;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      err_q    <= WERR_NONE;
      cur_q    <= '0;
      widx_q   <= '0;
      in_pkt_q <= 1'b0;
      done_q   <= 1'b0;
      proto_q  <= 1'b0;
      cpl_q    <= '0;
      dlen_q   <= '0;
    end else begin
      state_q  <= state_d;
      err_q    <= err_d;
      cur_q    <= cur_d;
      widx_q   <= widx_d;
      in_pkt_q <= in_pkt_d;
      done_q   <= done_d;
      proto_q  <= proto_d;
      cpl_q    <= cpl_d;
      dlen_q   <= dlen_d;
    end
  end

  // data registers, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (bd_en) bd_q[widx_q] <= eng_rdata;
    if (sop_en) begin
      sop_ptr_q <= cur_q;
      sop_w3_q  <= bd_q[3];
      plen_q    <= bd_q[3][HALF_W-1:0];
    end
  end

  assign frag_req  = (state_q == ST_REQ);
  assign frag_addr = bd_q[1];
  assign frag_off  = bd_q[2][WORD_W-1:HALF_W];
  assign frag_len  = bd_q[2][HALF_W-1:0];
  assign pkt_done  = done_q;
  assign cpl_ptr   = cpl_q;
  assign done_len  = dlen_q;
  assign busy      = (state_q != ST_IDLE);
  assign err_code  = err_q;
  assign proto_err = proto_q;

  // R3: start behaviour
  p_head_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (head_wr && (head_wdata != '0) && !busy) |=> busy);
  p_head_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (head_wr && (head_wdata == '0) && !busy) |=> !busy);
  // R4: request held stable until acknowledged
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frag_req && !frag_ack) |=> (frag_req && $stable(frag_addr) &&
                                 $stable(frag_off) && $stable(frag_len)));
  // R5: an error code means no data moves
  p_err_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'd0) |-> !frag_req);
  // R7: a done strobe always follows an ownership write-back
  p_done_after_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> $past(eng_we));
  // R9: done is a single-cycle strobe
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);
  // R12: protocol error only for a write during a walk
  p_proto_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(busy));
endmodule

// File: rtl/bd_chain_walker.sv
module bd_chain_walker
  import bdw_pkg::*;
#(
  parameter int RAM_WORDS = 64,
  localparam int IDX_W    = $clog2(RAM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_wr,
  input  logic [WORD_W-1:0] head_wdata,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              frag_req,
  input  logic              frag_ack,
  output logic [WORD_W-1:0] frag_addr,
  output logic [HALF_W-1:0] frag_off,
  output logic [HALF_W-1:0] frag_len,
  output logic              pkt_done,
  output logic [WORD_W-1:0] cpl_ptr,
  output logic [HALF_W-1:0] done_len,
  output logic              busy,
  output logic [1:0]        err_code,
  output logic              proto_err
);
  logic              rst_s0, rst_s1;
  logic [IDX_W-1:0]  eng_raddr, eng_waddr;
  logic [WORD_W-1:0] eng_rdata, eng_wdata;
  logic              eng_we;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end

  bdw_desc_ram #(.WORDS(RAM_WORDS), .DW(WORD_W)) u_ram (
    .clk        (clk),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .eng_raddr  (eng_raddr),
    .eng_rdata  (eng_rdata),
    .eng_we     (eng_we),
    .eng_waddr  (eng_waddr),
    .eng_wdata  (eng_wdata)
  );

  bdw_walk_ctrl #(.RAM_WORDS(RAM_WORDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s1),
    .head_wr    (head_wr),
    .head_wdata (head_wdata),
    .frag_ack   (frag_ack),
    .frag_req   (frag_req),
    .frag_addr  (frag_addr),
    .frag_off   (frag_off),
    .frag_len   (frag_len),
    .pkt_done   (pkt_done),
    .cpl_ptr    (cpl_ptr),
    .done_len   (done_len),
    .busy       (busy),
    .err_code   (err_code),
    .proto_err  (proto_err),
    .eng_raddr  (eng_raddr),
    .eng_rdata  (eng_rdata),
    .eng_we     (eng_we),
    .eng_waddr  (eng_waddr),
    .eng_wdata  (eng_wdata)
  );
endmodule

// File: tb/bd_chain_walker_bench.sv
module bd_chain_walker_bench;
  localparam int WORDS = 64;
  localparam logic [31:0] F_SOP = 32'h8000_0000;
  localparam logic [31:0] F_EOP = 32'h4000_0000;
  localparam logic [31:0] F_OWN = 32'h2000_0000;
  localparam logic [31:0] F_EOQ = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        head_wr = 1'b0;
  logic [31:0] head_wdata = '0;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        frag_req, frag_ack = 1'b0;
  logic [31:0] frag_addr, cpl_ptr;
  logic [15:0] frag_off, frag_len, done_len;
  logic        pkt_done, busy, proto_err;
  logic [1:0]  err_code;

  logic [31:0] mdl [WORDS];
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bd_chain_walker #(.RAM_WORDS(WORDS)) u_bd_chain_walker (
    .clk(clk), .rst_n(rst_n), .head_wr(head_wr), .head_wdata(head_wdata),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .frag_req(frag_req), .frag_ack(frag_ack),
    .frag_addr(frag_addr), .frag_off(frag_off), .frag_len(frag_len),
    .pkt_done(pkt_done), .cpl_ptr(cpl_ptr), .done_len(done_len),
    .busy(busy), .err_code(err_code), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic host_wr(input int idx, input logic [31:0] d);
    host_we = 1'b1; host_addr = idx[5:0]; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input int idx, output logic [31:0] d);
    host_addr = idx[5:0];
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic load_slot(input int s);
    for (int k = 0; k < 4; k++) host_wr(s * 4 + k, mdl[s * 4 + k]);
  endtask

  function automatic logic [31:0] mk_desc_w3(input bit sop, input bit eop,
                                             input bit own, input logic [15:0] len);
    return (sop ? F_SOP : 32'h0) | (eop ? F_EOP : 32'h0) |
           (own ? F_OWN : 32'h0) | {16'h0, len};
  endfunction

  // walk the chain from head, predicting every result from the model
  task automatic walk(input logic [31:0] head, input bit poke);
    logic [31:0] cur, sop;
    logic [15:0] plen;
    bit in_pkt, stop;
    int mism;
    logic [31:0] rd;
    cur = head; sop = '0; plen = '0; in_pkt = 0; stop = 0;
    head_wr = 1'b1; head_wdata = head;
    @(negedge clk);
    head_wr = 1'b0;
    chk(busy == 1'b1, "R3 busy after start", busy, 1);
    chk(err_code == 2'd0, "R14 error cleared by start", err_code, 0);
    if (poke) begin
      head_wr = 1'b1; head_wdata = 32'h0000_00F0;
      @(negedge clk);
      head_wr = 1'b0;
      chk(proto_err == 1'b1, "R12 proto_err after busy write", proto_err, 1);
      @(negedge clk);
      chk(proto_err == 1'b0, "R12 proto_err single cycle", proto_err, 0);
    end
    while (!stop) begin
      logic [31:0] w0, w1, w2, w3;
      int base, e;
      base = int'(cur >> 2);
      w0 = mdl[base]; w1 = mdl[base + 1]; w2 = mdl[base + 2]; w3 = mdl[base + 3];
      e = 0;
      if (!in_pkt) begin
        if (!w3[31]) e = 2;
        else if (!w3[29]) e = 1;
        else begin sop = cur; in_pkt = 1; plen = w3[15:0]; end
      end
      if (e != 0) begin
        bit seen;
        seen = 0;
        repeat (10) begin @(negedge clk); if (frag_req) seen = 1; end
        chk(!seen, (e == 1) ? "R5 no request for unowned packet" :
                              "R6 no request without start mark", seen, 0);
        chk(err_code == e[1:0], (e == 1) ? "R5 error code" : "R6 error code",
            err_code, e);
        chk(busy == 1'b0, "R5 R6 engine stopped", busy, 0);
        stop = 1;
      end else begin
        int t;
        t = 0;
        while (!frag_req && t < 12) begin @(negedge clk); t++; end
        chk(frag_req == 1'b1, "R4 request issued", frag_req, 1);
        chk({frag_addr, frag_off, frag_len} == {w1, w2},
            "R4 fragment fields", {frag_addr, frag_off, frag_len}, {w1, w2});
        if (cur != sop) begin
          host_rd(int'(sop >> 2) + 3, rd);
          chk(rd[29] == 1'b1, "R7 ownership kept before packet end", rd, rd | F_OWN);
        end
        repeat ($urandom_range(0, 3)) @(negedge clk);
        frag_ack = 1'b1;
        @(negedge clk);
        frag_ack = 1'b0;
        if (w3[30]) begin
          bit lastd, got;
          int k, kexp;
          lastd = (w0 == 32'h0);
          kexp = (lastd && cur != sop) ? 3 : 2;
          k = 1; got = pkt_done;
          while (!got && k < 8) begin @(negedge clk); k++; got = pkt_done; end
          chk(got && k == kexp, "R9 done strobe timing", k, kexp);
          chk(cpl_ptr == cur, "R9 completion pointer", cpl_ptr, cur);
          chk(done_len == plen, "R9 packet length", done_len, plen);
          if (lastd) mdl[base + 3] = mdl[base + 3] | F_EOQ;
          mdl[int'(sop >> 2) + 3] = mdl[int'(sop >> 2) + 3] & ~F_OWN;
          in_pkt = 0;
          if (lastd) begin
            chk(busy == 1'b0, "R10 stops at null next", busy, 0);
            stop = 1;
          end else cur = w0;
        end else if (w0 == 32'h0) begin
          chk(err_code == 2'd3 && busy == 1'b0, "R11 truncated chain",
              {busy, err_code}, 3);
          stop = 1;
        end else cur = w0;
      end
    end
    mism = 0;
    for (int i = 0; i < WORDS; i++) begin
      host_rd(i, rd);
      if (rd != mdl[i]) mism++;
    end
    chk(mism == 0, "R7 R8 write-back image", mism, 0);
  endtask

  task automatic build_random(output logic [31:0] head);
    int slots [15];
    int used, npk;
    for (int i = 0; i < 15; i++) slots[i] = i + 1;
    for (int i = 14; i > 0; i--) begin
      int j, tmp;
      j = $urandom_range(0, i);
      tmp = slots[i]; slots[i] = slots[j]; slots[j] = tmp;
    end
    head = 32'(slots[0] * 16);
    used = 0;
    npk = $urandom_range(1, 3);
    for (int p = 0; p < npk; p++) begin
      int nf;
      logic [15:0] plen;
      nf = $urandom_range(1, 3);
      plen = 16'($urandom_range(1, 2000));
      for (int f = 0; f < nf; f++) begin
        int s;
        bit lastall, own;
        s = slots[used];
        lastall = (p == npk - 1) && (f == nf - 1);
        own = (f == 0) ? ($urandom_range(0, 9) != 0) : 1'($urandom_range(0, 1));
        mdl[s * 4]     = lastall ? 32'h0 : 32'(slots[used + 1] * 16);
        mdl[s * 4 + 1] = $urandom;
        mdl[s * 4 + 2] = $urandom;
        mdl[s * 4 + 3] = mk_desc_w3(f == 0, f == nf - 1, own,
                                    (f == 0) ? plen : 16'($urandom));
        load_slot(s);
        used++;
      end
    end
  endtask

  initial begin
    logic [31:0] rd, head;
    void'($urandom(32'd20240611));
    for (int i = 0; i < WORDS; i++) mdl[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && frag_req == 1'b0, "R1 idle after reset", {busy, frag_req}, 0);
    chk(pkt_done == 1'b0 && proto_err == 1'b0, "R1 strobes low", {pkt_done, proto_err}, 0);
    chk(err_code == 2'd0 && cpl_ptr == 32'h0, "R1 status zero", {err_code, cpl_ptr}, 0);

    for (int i = 0; i < WORDS; i++) host_wr(i, 32'h0);

    // R13 host port
    mdl[5] = 32'hA5A5_1234;
    host_wr(5, mdl[5]);
    host_rd(5, rd);
    chk(rd == mdl[5], "R13 host read-back", rd, mdl[5]);
    host_rd(6, rd);
    chk(rd == 32'h0, "R13 host read other word", rd, 0);

    // R3 zero start ignored
    head_wr = 1'b1; head_wdata = 32'h0;
    @(negedge clk);
    head_wr = 1'b0;
    chk(busy == 1'b0, "R3 zero start ignored", busy, 0);
    repeat (6) @(negedge clk);
    chk(busy == 1'b0 && frag_req == 1'b0, "R3 still idle", {busy, frag_req}, 0);

    // single-buffer packet at the chain tail (R2 R8 same-descriptor end-of-queue)
    mdl[8] = 32'h0; mdl[9] = 32'h1000_0000; mdl[10] = {16'd4, 16'd60};
    mdl[11] = mk_desc_w3(1, 1, 1, 16'd60);
    load_slot(2);
    walk(32'd32, 0);

    // three-fragment packet then a one-buffer packet, with a stray start write
    mdl[12] = 32'd80;  mdl[13] = 32'h2000_0000; mdl[14] = {16'd0, 16'd100};
    mdl[15] = mk_desc_w3(1, 0, 1, 16'd300);
    mdl[20] = 32'd112; mdl[21] = 32'h2000_1000; mdl[22] = {16'd8, 16'd100};
    mdl[23] = mk_desc_w3(0, 0, 0, 16'd0);
    mdl[28] = 32'd144; mdl[29] = 32'h2000_2000; mdl[30] = {16'd2, 16'd100};
    mdl[31] = mk_desc_w3(0, 1, 1, 16'd0);
    mdl[36] = 32'h0;   mdl[37] = 32'h3000_0000; mdl[38] = {16'd0, 16'd64};
    mdl[39] = mk_desc_w3(1, 1, 1, 16'd64);
    load_slot(3); load_slot(5); load_slot(7); load_slot(9);
    walk(32'd48, 1);

    // R6 missing start mark, and R14 error held while idle
    mdl[16] = 32'h0; mdl[17] = 32'h4000_0000; mdl[18] = {16'd0, 16'd10};
    mdl[19] = mk_desc_w3(0, 1, 1, 16'd10);
    load_slot(4);
    walk(32'd64, 0);
    repeat (5) @(negedge clk);
    chk(err_code == 2'd2, "R14 error held while idle", err_code, 2);

    // R5 unowned packet
    mdl[24] = 32'h0; mdl[25] = 32'h5000_0000; mdl[26] = {16'd0, 16'd20};
    mdl[27] = mk_desc_w3(1, 1, 0, 16'd20);
    load_slot(6);
    walk(32'd96, 0);

    // R11 chain ends inside a packet
    mdl[40] = 32'h0; mdl[41] = 32'h6000_0000; mdl[42] = {16'd0, 16'd30};
    mdl[43] = mk_desc_w3(1, 0, 1, 16'd90);
    load_slot(10);
    walk(32'd160, 0);

    // constrained random chains
    for (int it = 0; it < 25; it++) begin
      build_random(head);
      walk(head, ($urandom_range(0, 3) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule